// File: doc/BRIEF.md
# Clock Stop Gating Unit

This unit sits between the clock sources of a clock generator and its output pins. It takes four source clocks (a processor clock, a buffered memory clock, a fixed interrupt-controller clock and a bus clock) and drives several copies of each. Each copy can be stopped low without a runt pulse. In every group except the interrupt-controller one, lane 0 is free-running. The other lanes are gated. Two active-low stop requests arrive asynchronously. One applies to the processor-side groups. The other applies to the bus group and is captured on the bus clock's rising edge.

Every lane also has a software enable. When that enable is clear, the lane is held low whatever the stop inputs do. The enables and the stop requests pass through the same capture path, so a lane switches on or off only during its clock's low phase. Its first pulse after a start therefore always has full width.

Top module: `clock_stop_gate`

## Requirements
- R1: While `rstN` is low, every output is held at 0.
- R2: Some lanes follow the processor-side stop: lanes 1 and above of `cpuOut`, lanes 1 and above of `sdramOut`, and `apicOut`. For each of these, the high phase of cycle n of its own source clock appears only if `cpuStopN` and the lane's enable bit were both 1 at rising edge n-2 of that clock. Otherwise the output stays 0 for the whole cycle. So after `cpuStopN` falls, exactly two more full pulses appear.
- R3: When `cpuStopN` rises again, the first pulse on a processor-side gated lane begins more than 2 and at most 3 periods of its clock later.
- R4: Lanes 1 and above of `pciOut` carry the high phase of `pciClk` cycle n only if `pciStopN` and the lane's enable were both 1 at rising edge n-1 of `pciClk`. After `pciStopN` falls, exactly one more pulse appears.
- R5: Lane 0 of `cpuOut`, `sdramOut` and `pciOut` is free-running. It ignores both stop inputs and follows only its own enable, with the same latency as its group.
- R6: An enable bit at 0 holds its lane at 0. The bit takes effect with the same latency as that group's stop input: 2 clock edges on the processor side, 1 on the bus side.
- R7: Every high and low pulse on every output lasts at least half a nominal period of its source clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpuClk | input | 1 | Processor clock source |
| sdramClk | input | 1 | Memory clock source (buffered input) |
| apicClk | input | 1 | Interrupt-controller clock source |
| pciClk | input | 1 | Bus clock source |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuStopN | input | 1 | Asynchronous stop for the processor-side gated lanes, 0 = stop |
| pciStopN | input | 1 | Stop for the bus gated lanes, captured on rising `pciClk`, 0 = stop |
| cpuEn | input | NUM_CPU_GATED+1 | Software enables for `cpuOut`, bit 0 = free lane |
| sdramEn | input | NUM_SDRAM_GATED+1 | Software enables for `sdramOut`, bit 0 = free lane |
| apicEn | input | 1 | Software enable for `apicOut` |
| pciEn | input | NUM_PCI_GATED+1 | Software enables for `pciOut`, bit 0 = free lane |
| cpuOut | output | NUM_CPU_GATED+1 | Processor clock copies |
| sdramOut | output | NUM_SDRAM_GATED+1 | Memory clock copies |
| apicOut | output | 1 | Gated interrupt-controller clock |
| pciOut | output | NUM_PCI_GATED+1 | Bus clock copies |

## Verification
Assertions check several things on every cycle in each domain:
- the synchronized stop and enable values lag their inputs by exactly the capture depth;
- a gated lane carries no pulse after a sampled stop;
- a disabled lane stays low;
- an enabled free lane always pulses.

Only the bench scenarios can show the end-to-end timing. These cover the exact count of trailing pulses after a stop, the 2-to-3-period restart window, and the one-cycle lag of the bus stop. They also show that no pulse shrinks when stops and enables toggle at arbitrary phases against four unrelated clocks.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  // Widest lane group any domain may carry.
  localparam int MAX_LANES = 16;

  // Strobes from a domain's capture logic to its gating datapath.
  typedef struct packed {
    logic                 stopRun;  // synchronized stop input, 1 = run
    logic [MAX_LANES-1:0] laneEn;   // synchronized software enables
  } gateCtl_t;

endpackage

// File: rtl/stopSyncCtrl.sv
`timescale 1ns/1ps
module stopSyncCtrl
  import clkstop_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runReq,
  input  logic [LANES-1:0] laneReq,
  output gateCtl_t         ctl
);

  localparam int VW = LANES + 1;

  logic [VW-1:0] syncQ [STAGES];

  // Rising-edge capture chain, stop bit on top of the enable bits.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= {runReq, laneReq};
      for (int s = 1; s < STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  always_comb begin
    ctl                   = '0;
    ctl.stopRun           = syncQ[STAGES-1][LANES];
    ctl.laneEn[LANES-1:0] = syncQ[STAGES-1][LANES-1:0];
  end

  // Edges seen since reset, so that the delay checks never look back into reset.
  logic [3:0] warmCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      warmCnt <= '0;
    else if (warmCnt != 4'(STAGES)) warmCnt <= warmCnt + 4'd1;
  end

  // Stop capture depth: 2 edges processor side (R2), 1 edge bus side (R4).
  assert_sync_depth_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 4'(STAGES)) |-> (ctl.stopRun == $past(runReq, STAGES)));

  assert_enable_depth_R6: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt == 4'(STAGES)) |-> (ctl.laneEn[LANES-1:0] == $past(laneReq, STAGES)));

endmodule

// File: rtl/gateDatapath.sv
`timescale 1ns/1ps
module gateDatapath
  import clkstop_pkg::*;
#(
  parameter int               LANES     = 2,
  parameter logic [LANES-1:0] FREE_MASK = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateCtl_t         ctl,
  output logic [LANES-1:0] clkOut
);

  logic [LANES-1:0] gateD;
  logic [LANES-1:0] gateQ;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      gateD[i] = ctl.laneEn[i] & (FREE_MASK[i] | ctl.stopRun);
  end

  // Falling-edge gate register: it only changes while the source clock is low.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= gateD;
  end

  assign clkOut = gateQ & {LANES{clk}};

  // A stop seen at the previous falling edge leaves no pulse on gated lanes.
  assert_stop_holds_low_R2: assert property (@(negedge clk) disable iff (!rstN)
    !$past(ctl.stopRun) |-> ((clkOut & ~FREE_MASK) == '0));

  // A lane whose enable was clear carries no pulse.
  assert_lane_off_R6: assert property (@(negedge clk) disable iff (!rstN)
    ((~$past(ctl.laneEn[LANES-1:0]) & clkOut) == '0));

  // An enabled free lane always pulses.
  assert_free_runs_R5: assert property (@(negedge clk) disable iff (!rstN)
    (($past(ctl.laneEn[LANES-1:0]) & FREE_MASK & ~clkOut) == '0));

endmodule

// File: rtl/clock_stop_gate.sv
`timescale 1ns/1ps
module clock_stop_gate
  import clkstop_pkg::*;
#(
  parameter int NUM_CPU_GATED   = 1,
  parameter int NUM_SDRAM_GATED = 12,
  parameter int NUM_PCI_GATED   = 5,
  parameter int CPU_SYNC        = 2,
  parameter int PCI_SYNC        = 1
) (
  input  logic                     cpuClk,
  input  logic                     sdramClk,
  input  logic                     apicClk,
  input  logic                     pciClk,
  input  logic                     rstN,
  input  logic                     cpuStopN,
  input  logic                     pciStopN,
  input  logic [NUM_CPU_GATED:0]   cpuEn,
  input  logic [NUM_SDRAM_GATED:0] sdramEn,
  input  logic                     apicEn,
  input  logic [NUM_PCI_GATED:0]   pciEn,
  output logic [NUM_CPU_GATED:0]   cpuOut,
  output logic [NUM_SDRAM_GATED:0] sdramOut,
  output logic                     apicOut,
  output logic [NUM_PCI_GATED:0]   pciOut
);

  localparam int CPU_LANES   = NUM_CPU_GATED + 1;
  localparam int SDRAM_LANES = NUM_SDRAM_GATED + 1;
  localparam int PCI_LANES   = NUM_PCI_GATED + 1;
  localparam logic [CPU_LANES-1:0]   CPU_FREE   = CPU_LANES'(1);
  localparam logic [SDRAM_LANES-1:0] SDRAM_FREE = SDRAM_LANES'(1);
  localparam logic [PCI_LANES-1:0]   PCI_FREE   = PCI_LANES'(1);

  gateCtl_t cpuCtl, sdramCtl, apicCtl, pciCtl;
  logic [0:0] apicVec;

  stopSyncCtrl #(.LANES(CPU_LANES), .STAGES(CPU_SYNC)) u_cpuCtrl (
    .clk(cpuClk), .rstN(rstN), .runReq(cpuStopN), .laneReq(cpuEn), .ctl(cpuCtl));
  gateDatapath #(.LANES(CPU_LANES), .FREE_MASK(CPU_FREE)) u_cpuDp (
    .clk(cpuClk), .rstN(rstN), .ctl(cpuCtl), .clkOut(cpuOut));

  stopSyncCtrl #(.LANES(SDRAM_LANES), .STAGES(CPU_SYNC)) u_sdramCtrl (
    .clk(sdramClk), .rstN(rstN), .runReq(cpuStopN), .laneReq(sdramEn), .ctl(sdramCtl));
  gateDatapath #(.LANES(SDRAM_LANES), .FREE_MASK(SDRAM_FREE)) u_sdramDp (
    .clk(sdramClk), .rstN(rstN), .ctl(sdramCtl), .clkOut(sdramOut));

  stopSyncCtrl #(.LANES(1), .STAGES(CPU_SYNC)) u_apicCtrl (
    .clk(apicClk), .rstN(rstN), .runReq(cpuStopN), .laneReq(apicEn), .ctl(apicCtl));
  gateDatapath #(.LANES(1), .FREE_MASK(1'b0)) u_apicDp (
    .clk(apicClk), .rstN(rstN), .ctl(apicCtl), .clkOut(apicVec));
  assign apicOut = apicVec[0];

  stopSyncCtrl #(.LANES(PCI_LANES), .STAGES(PCI_SYNC)) u_pciCtrl (
    .clk(pciClk), .rstN(rstN), .runReq(pciStopN), .laneReq(pciEn), .ctl(pciCtl));
  gateDatapath #(.LANES(PCI_LANES), .FREE_MASK(PCI_FREE)) u_pciDp (
    .clk(pciClk), .rstN(rstN), .ctl(pciCtl), .clkOut(pciOut));

endmodule

// File: tb/sim_clock_stop_gate.sv
`timescale 1ns/100ps
module sim_clock_stop_gate;

  localparam int CPU_PERIOD   = 10;
  localparam int SDRAM_PERIOD = 8;
  localparam int APIC_PERIOD  = 14;
  localparam int PCI_PERIOD   = 30;
  localparam int CPU_LANES    = 2;
  localparam int SDRAM_LANES  = 13;
  localparam int PCI_LANES    = 6;
  localparam int NMON = CPU_LANES + SDRAM_LANES + 1 + PCI_LANES;

  logic cpuClk = 0, sdramClk = 0, apicClk = 0, pciClk = 0;
  logic rstN = 1;
  logic cpuStopN, pciStopN, apicEn;
  logic [CPU_LANES-1:0]   cpuEn;
  logic [SDRAM_LANES-1:0] sdramEn;
  logic [PCI_LANES-1:0]   pciEn;
  logic [CPU_LANES-1:0]   cpuOut;
  logic [SDRAM_LANES-1:0] sdramOut;
  logic                   apicOut;
  logic [PCI_LANES-1:0]   pciOut;

  int testsRun = 0;
  int failCnt  = 0;
  bit doneFlag = 0;

  always #(CPU_PERIOD/2)   cpuClk   = ~cpuClk;
  always #(SDRAM_PERIOD/2) sdramClk = ~sdramClk;
  always #(APIC_PERIOD/2)  apicClk  = ~apicClk;
  always #(PCI_PERIOD/2)   pciClk   = ~pciClk;

  clock_stop_gate u0 (
    .cpuClk(cpuClk), .sdramClk(sdramClk), .apicClk(apicClk), .pciClk(pciClk),
    .rstN(rstN), .cpuStopN(cpuStopN), .pciStopN(pciStopN),
    .cpuEn(cpuEn), .sdramEn(sdramEn), .apicEn(apicEn), .pciEn(pciEn),
    .cpuOut(cpuOut), .sdramOut(sdramOut), .apicOut(apicOut), .pciOut(pciOut));

  task automatic checkVec(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic checkTrue(input string tag, input bit ok, input int got, input int exp);
    testsRun++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, failCnt);
      $finish;
    end
  endtask

  // Reference model: requests sampled at each rising edge, replayed two
  // (processor side) or one (bus side) cycles later; low phase always 0.
  logic [15:0] cpuH1 = '0, cpuH2 = '0, cpuExp, cpuReq;
  always @(posedge cpuClk) begin
    cpuReq = '0;
    cpuReq[CPU_LANES-1:0] = cpuEn & ({CPU_LANES{cpuStopN}} | CPU_LANES'(1));
    cpuExp = cpuH2;
    if (!rstN) begin cpuH1 = '0; cpuH2 = '0; cpuExp = '0; end
    else begin cpuH2 = cpuH1; cpuH1 = cpuReq; end
    #(CPU_PERIOD/4);
    checkVec("R2 cpu high phase", 32'(cpuOut), 32'(cpuExp));
    #(CPU_PERIOD/2);
    checkVec("R2 cpu low phase", 32'(cpuOut), 32'h0);
  end

  logic [15:0] sdH1 = '0, sdH2 = '0, sdExp, sdReq;
  always @(posedge sdramClk) begin
    sdReq = '0;
    sdReq[SDRAM_LANES-1:0] = sdramEn & ({SDRAM_LANES{cpuStopN}} | SDRAM_LANES'(1));
    sdExp = sdH2;
    if (!rstN) begin sdH1 = '0; sdH2 = '0; sdExp = '0; end
    else begin sdH2 = sdH1; sdH1 = sdReq; end
    #(SDRAM_PERIOD/4);
    checkVec("R2 sdram high phase", 32'(sdramOut), 32'(sdExp));
    #(SDRAM_PERIOD/2);
    checkVec("R2 sdram low phase", 32'(sdramOut), 32'h0);
  end

  logic apH1 = 0, apH2 = 0, apExp;
  always @(posedge apicClk) begin
    apExp = apH2;
    if (!rstN) begin apH1 = 0; apH2 = 0; apExp = 0; end
    else begin apH2 = apH1; apH1 = apicEn & cpuStopN; end
    #(APIC_PERIOD/4);
    checkVec("R2 apic high phase", 32'(apicOut), 32'(apExp));
    #(APIC_PERIOD/2);
    checkVec("R2 apic low phase", 32'(apicOut), 32'h0);
  end

  logic [15:0] pcH1 = '0, pcExp, pcReq;
  always @(posedge pciClk) begin
    pcReq = '0;
    pcReq[PCI_LANES-1:0] = pciEn & ({PCI_LANES{pciStopN}} | PCI_LANES'(1));
    pcExp = pcH1;
    if (!rstN) begin pcH1 = '0; pcExp = '0; end
    else pcH1 = pcReq;
    #(PCI_PERIOD/4);
    checkVec("R4 pci high phase", 32'(pciOut), 32'(pcExp));
    #(PCI_PERIOD/2);
    checkVec("R4 pci low phase", 32'(pciOut), 32'h0);
  end

  // Rising-edge counters for the directed windows.
  int cpuGatedRises = 0, cpuFreeRises = 0, sdGatedRises = 0, sdFreeRises = 0;
  int sdLane5Rises = 0, apicRises = 0, pciGatedRises = 0, pciFreeRises = 0;
  always @(posedge cpuOut[1])   cpuGatedRises++;
  always @(posedge cpuOut[0])   cpuFreeRises++;
  always @(posedge sdramOut[1]) sdGatedRises++;
  always @(posedge sdramOut[0]) sdFreeRises++;
  always @(posedge sdramOut[5]) sdLane5Rises++;
  always @(posedge apicOut)     apicRises++;
  always @(posedge pciOut[1])   pciGatedRises++;
  always @(posedge pciOut[0])   pciFreeRises++;

  // R7 pulse-width monitor on every output lane.
  wire [NMON-1:0] monSig = {pciOut, apicOut, sdramOut, cpuOut};

  function automatic realtime halfNom(input int idx);
    if (idx < CPU_LANES)                    return realtime'(CPU_PERIOD) / 2.0;
    if (idx < CPU_LANES + SDRAM_LANES)      return realtime'(SDRAM_PERIOD) / 2.0;
    if (idx == CPU_LANES + SDRAM_LANES)     return realtime'(APIC_PERIOD) / 2.0;
    return realtime'(PCI_PERIOD) / 2.0;
  endfunction

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    realtime lastEdge = 0;
    bit seen = 0;
    always @(monSig[g]) begin
      if (seen && rstN) begin
        testsRun++;
        if ($realtime - lastEdge < halfNom(g)) begin
          failCnt++;
          $display("FAIL R7 lane %0d pulse: actual %0t expected >= %0t", g,
                   $realtime - lastEdge, halfNom(g));
        end
      end
      seen = 1;
      lastEdge = $realtime;
    end
  end

  initial begin
    #200000;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  int c0, c1, c2, c3, c4, c5;
  realtime t0;

  initial begin
    cpuStopN = 1; pciStopN = 1; apicEn = 1;
    cpuEn = '1; sdramEn = '1; pciEn = '1;
    #0.2 rstN = 0;
    #10.3;
    checkVec("R1 reset outputs", 32'(monSig), 32'h0);
    #20;
    checkVec("R1 reset outputs", 32'(monSig), 32'h0);
    #10 rstN = 1;
    #300;

    // R2: processor-side stop, two trailing pulses on each gated lane.
    c0 = cpuGatedRises; c1 = cpuFreeRises; c2 = sdGatedRises; c3 = sdFreeRises; c4 = apicRises;
    cpuStopN = 0;
    #100;
    checkTrue("R2 cpu trailing pulses", cpuGatedRises - c0 == 2, cpuGatedRises - c0, 2);
    checkTrue("R2 sdram trailing pulses", sdGatedRises - c2 == 2, sdGatedRises - c2, 2);
    checkTrue("R2 apic trailing pulses", apicRises - c4 == 2, apicRises - c4, 2);
    checkTrue("R5 cpu free lane runs", cpuFreeRises - c1 == 10, cpuFreeRises - c1, 10);
    checkTrue("R5 sdram free lane runs", sdFreeRises - c3 >= 12, sdFreeRises - c3, 12);

    // R4: bus stop, one trailing pulse.
    c0 = pciGatedRises; c1 = pciFreeRises;
    pciStopN = 0;
    #200;
    checkTrue("R4 pci trailing pulses", pciGatedRises - c0 == 1, pciGatedRises - c0, 1);
    checkTrue("R5 pci free lane runs", pciFreeRises - c1 >= 6, pciFreeRises - c1, 6);
    pciStopN = 1;
    #100;

    // R3: restart latency on the processor-side gated lane.
    cpuStopN = 1;
    t0 = $realtime;
    @(posedge cpuOut[1]);
    checkTrue("R3 restart delay", ($realtime - t0 > 20) && ($realtime - t0 <= 30),
              int'($realtime - t0), 25);
    #0.5;
    #200;

    // R6: cleared enables hold their lanes low, others keep running.
    cpuEn[1] = 0; sdramEn[5] = 0; apicEn = 0; pciEn[0] = 0;
    #150;
    c0 = cpuGatedRises; c1 = sdLane5Rises; c2 = apicRises; c3 = pciFreeRises;
    c4 = cpuFreeRises; c5 = sdGatedRises;
    #150;
    checkTrue("R6 cpu lane disabled", cpuGatedRises == c0, cpuGatedRises - c0, 0);
    checkTrue("R6 sdram lane 5 disabled", sdLane5Rises == c1, sdLane5Rises - c1, 0);
    checkTrue("R6 apic disabled", apicRises == c2, apicRises - c2, 0);
    checkTrue("R6 pci free lane disabled", pciFreeRises == c3, pciFreeRises - c3, 0);
    checkTrue("R6 cpu free lane unaffected", cpuFreeRises - c4 == 15, cpuFreeRises - c4, 15);
    checkTrue("R6 sdram lane 1 unaffected", sdGatedRises - c5 >= 18, sdGatedRises - c5, 18);
    cpuEn = '1; sdramEn = '1; apicEn = 1; pciEn = '1;
    #200;

    // Arbitrary-phase toggling; the model and the R7 monitor check every cycle.
    for (int k = 0; k < 80; k++) begin
      #($urandom_range(3, 40));
      case ($urandom_range(0, 5))
        0: cpuStopN = ~cpuStopN;
        1: pciStopN = ~pciStopN;
        2: cpuEn    = CPU_LANES'($urandom);
        3: sdramEn  = SDRAM_LANES'($urandom);
        4: pciEn    = PCI_LANES'($urandom);
        default: apicEn = ~apicEn;
      endcase
    end

    cpuStopN = 1; pciStopN = 1; apicEn = 1;
    cpuEn = '1; sdramEn = '1; pciEn = '1;
    #400;
    finishRun();
  end

endmodule